// File: doc/BRIEF.md
# Board Control Register Block

This block is a small bank of memory-mapped control registers for an evaluation board, placed on a plain 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe with combinational read data. The block holds an LED bar value and an eight-character ASCII display buffer. It also holds a break/reset byte, a general-purpose output byte, and two-bit I2C pin controls with a select bit. Software can fill the display one character at a time. It can also fill the whole buffer at once by writing a 32-bit word, which the block turns into eight uppercase hexadecimal digits.

A write of one magic value to the soft-reset location produces a single-cycle reset request for the rest of the system. A few locations return fixed values: the switch and jumper words, the I2C input, and a status word that reports the configured byte order. Only the low address bits are decoded, so the register window repeats throughout the address space.

Top module: `board_ctl_regs`

## Requirements
- R1: Only address bits [19:0] are decoded; an access with any upper bits set behaves exactly as the same access with those bits clear.
- R2: The LED register at offset 0x408 stores bits [7:0] of a write, drives them on `led_o` and reads them back zero-extended.
- R3: A write to offset 0x410 replaces all eight display characters with the uppercase ASCII hex digits (0x30-0x39, 0x41-0x46) of the data word. Character 0 holds bits [31:28] and character 7 holds bits [3:0].
- R4: A write to offset 0x418 + 8*i (i = 0..7) sets display character i to data bits [7:0] and leaves the other characters unchanged. Character i appears on `disp_o[8*i+7:8*i]`.
- R5: A write of exactly 0x00000042 to offset 0x500 makes `rst_req_o` high for exactly the one cycle after that clock edge. Any other data written there leaves `rst_req_o` low.
- R6: The break register (0x508) and the general-purpose output (0xA00) each store 8 bits, read back, and reset to 0x0A and 0x00.
- R7: The I2C output-enable register (0xB08) and the I2C output register (0xB10) each store data bits [1:0], read back, and reset to 0 and 3.
- R8: Offsets 0x200 and 0x210 read 0 and ignore writes. Offset 0xB00 reads 3. Offset 0x208 reads 0x12 when `BIG_ENDIAN` is 1 and 0x10 otherwise.
- R9: The I2C select register (0xB18) stores data bit 0, reads it back and resets to 1. Offset 0xA08 reads the I2C output value while select is 1 and reads 0 while select is 0.
- R10: After reset `led_o` is 0 and every display character is ASCII space (0x20).
- R11: Reads of unmapped offsets return 0 and writes to them change no output or register. `rdata_o` is 0 whenever `rd_i` is low.
- R12: A read and a write to the same register in the same cycle return the value held before that write. The written value is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Bus byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational |
| led_o | output | 8 | LED bar bits |
| disp_o | output | 64 | Eight display characters, character i in bits [8i+7:8i] |
| brk_o | output | 8 | Break/reset register value |
| gpo_o | output | 8 | General-purpose outputs |
| i2c_oe_o | output | 2 | I2C output enables |
| i2c_out_o | output | 2 | I2C output levels |
| rst_req_o | output | 1 | One-cycle soft-reset request |

## Verification
Reading and writing can fall in the same cycle, so the read port can see a register in the very cycle its update is being captured. The bench raises both strobes together on the LED, general-purpose output and I2C select registers. It takes the read data before the edge and expects the old value, then reads again after the edge and expects the new one. A second overlap is a whole-word display write next to single-character writes. The bench checks that the last write to reach a character wins, by comparing the full display output with a model after every write of the random phase.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

   localparam int OFFS_W = 20;

   // register slot indices for the decode vector
   localparam int S_SWITCH  = 0;
   localparam int S_STATUS  = 1;
   localparam int S_JUMPER  = 2;
   localparam int S_LED     = 3;
   localparam int S_HEXWORD = 4;
   localparam int S_SOFTRST = 5;
   localparam int S_BRK     = 6;
   localparam int S_GPO     = 7;
   localparam int S_GPIN    = 8;
   localparam int S_I2CIN   = 9;
   localparam int S_I2COE   = 10;
   localparam int S_I2COUT  = 11;
   localparam int S_I2CSEL  = 12;
   localparam int NSLOT     = 13;

   localparam logic [OFFS_W-1:0] SLOT_OFFS [NSLOT] = '{
      20'h00200, 20'h00208, 20'h00210, 20'h00408, 20'h00410, 20'h00500,
      20'h00508, 20'h00A00, 20'h00A08, 20'h00B00, 20'h00B08, 20'h00B10,
      20'h00B18
   };

   localparam logic [OFFS_W-1:0] CHAR_BASE   = 20'h00418;
   localparam int                CHAR_STRIDE = 8;
   localparam logic [7:0]        ASCII_SPACE = 8'h20;

   function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
      if (nib < 4'd10) return 8'h30 + {4'h0, nib};
      else             return 8'h37 + {4'h0, nib};
   endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
   import board_ctl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEC_W  = OFFS_W,
   parameter int NCHAR  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NSLOT-1:0]  slot_hit_o,
   output logic [NCHAR-1:0]  char_hit_o
);

   logic [DEC_W-1:0] offs;
   assign offs = addr_i[DEC_W-1:0];

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assign slot_hit_o[k] = (offs == DEC_W'(SLOT_OFFS[k]));
   end

   for (genvar i = 0; i < NCHAR; i++) begin : g_char
      assign char_hit_o[i] = (offs == DEC_W'(CHAR_BASE + CHAR_STRIDE * i));
   end

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({slot_hit_o, char_hit_o})); // R1

endmodule

// File: rtl/bcr_display.sv
module bcr_display
   import board_ctl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NCHAR  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_we_i,
   input  logic [NCHAR-1:0]   char_we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [8*NCHAR-1:0] chars_o
);

   for (genvar i = 0; i < NCHAR; i++) begin : g_cell
      localparam int NIB_LO = 4 * (NCHAR - 1 - i);
      logic [7:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cell_q <= ASCII_SPACE;
         else if (word_we_i)      cell_q <= hex_ascii(wdata_i[NIB_LO +: 4]);
         else if (char_we_i[i])   cell_q <= wdata_i[7:0];
      end
      assign chars_o[8*i +: 8] = cell_q;
   end

   AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_we_i || (|char_we_i)) |=> $stable(chars_o)); // R4

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
   import board_ctl_pkg::*;
#(
   parameter int         ADDR_W     = 32,
   parameter int         DATA_W     = 32,
   parameter int         DEC_W      = OFFS_W,
   parameter int         NCHAR      = 8,
   parameter int         LED_W      = 8,
   parameter int         GPO_W      = 8,
   parameter int         I2C_W      = 2,
   parameter bit         BIG_ENDIAN = 1'b0,
   parameter logic [7:0] BRK_INIT   = 8'h0A,
   parameter logic [31:0] RST_MAGIC = 32'h0000_0042
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               rd_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic [LED_W-1:0]   led_o,
   output logic [8*NCHAR-1:0] disp_o,
   output logic [7:0]         brk_o,
   output logic [GPO_W-1:0]   gpo_o,
   output logic [I2C_W-1:0]   i2c_oe_o,
   output logic [I2C_W-1:0]   i2c_out_o,
   output logic               rst_req_o
);

   localparam logic [DATA_W-1:0] I2C_IN_VAL = DATA_W'(3);

   if (DEC_W < 12 || DEC_W > ADDR_W) begin : g_bad_dec
      $error("DEC_W must cover the register offsets and fit in ADDR_W");
   end
   if (DATA_W != 4 * NCHAR) begin : g_bad_char
      $error("DATA_W must supply one hex nibble per display character");
   end
   if (LED_W > DATA_W || GPO_W > DATA_W || I2C_W > DATA_W) begin : g_bad_w
      $error("register widths must fit the data bus");
   end

   logic [DATA_W-1:0] status_val;
   if (BIG_ENDIAN) begin : g_be
      assign status_val = DATA_W'(8'h12);
   end else begin : g_le
      assign status_val = DATA_W'(8'h10);
   end

   logic [NSLOT-1:0] slot_hit;
   logic [NCHAR-1:0] char_hit;

   bcr_decode #(.ADDR_W(ADDR_W), .DEC_W(DEC_W), .NCHAR(NCHAR)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (addr_i),
      .slot_hit_o (slot_hit),
      .char_hit_o (char_hit)
   );

   logic [NSLOT-1:0] slot_we;
   assign slot_we = slot_hit & {NSLOT{wr_i}};

   bcr_display #(.DATA_W(DATA_W), .NCHAR(NCHAR)) u_disp (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_we_i (slot_we[S_HEXWORD]),
      .char_we_i (char_hit & {NCHAR{wr_i}}),
      .wdata_i   (wdata_i),
      .chars_o   (disp_o)
   );

   logic             i2c_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_o     <= '0;
         brk_o     <= BRK_INIT;
         gpo_o     <= '0;
         i2c_oe_o  <= '0;
         i2c_out_o <= I2C_W'(3);
         i2c_sel_q <= 1'b1;
         rst_req_o <= 1'b0;
      end else begin
         if (slot_we[S_LED])    led_o     <= wdata_i[LED_W-1:0];
         if (slot_we[S_BRK])    brk_o     <= wdata_i[7:0];
         if (slot_we[S_GPO])    gpo_o     <= wdata_i[GPO_W-1:0];
         if (slot_we[S_I2COE])  i2c_oe_o  <= wdata_i[I2C_W-1:0];
         if (slot_we[S_I2COUT]) i2c_out_o <= wdata_i[I2C_W-1:0];
         if (slot_we[S_I2CSEL]) i2c_sel_q <= wdata_i[0];
         rst_req_o <= slot_we[S_SOFTRST] && (wdata_i == DATA_W'(RST_MAGIC));
      end
   end

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         if (slot_hit[S_STATUS]) rdata_o = status_val;
         if (slot_hit[S_LED])    rdata_o = DATA_W'(led_o);
         if (slot_hit[S_BRK])    rdata_o = DATA_W'(brk_o);
         if (slot_hit[S_GPO])    rdata_o = DATA_W'(gpo_o);
         if (slot_hit[S_GPIN])   rdata_o = i2c_sel_q ? DATA_W'(i2c_out_o) : '0;
         if (slot_hit[S_I2CIN])  rdata_o = I2C_IN_VAL;
         if (slot_hit[S_I2COE])  rdata_o = DATA_W'(i2c_oe_o);
         if (slot_hit[S_I2COUT]) rdata_o = DATA_W'(i2c_out_o);
         if (slot_hit[S_I2CSEL]) rdata_o = DATA_W'(i2c_sel_q);
      end
   end

   AST_RSTREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> $past(wr_i) && $past(slot_hit[S_SOFTRST])); // R5
   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_we[S_LED] |=> $stable(led_o)); // R2
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |-> rdata_o == '0); // R11
   AST_I2C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && slot_hit[S_I2COUT]) |=> $stable(i2c_out_o)); // R7

endmodule

// File: tb/sim_board_ctl_regs.sv
`timescale 1ns/1ps
module sim_board_ctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd = 1'b0;
   logic [31:0] rdata;
   logic [7:0]  led, brk, gpo;
   logic [63:0] disp;
   logic [1:0]  oe, outv;
   logic        rreq;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   board_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
      .rd_i(rd), .rdata_o(rdata), .led_o(led), .disp_o(disp), .brk_o(brk),
      .gpo_o(gpo), .i2c_oe_o(oe), .i2c_out_o(outv), .rst_req_o(rreq)
   );

   // bench model
   logic [7:0] m_led, m_brk, m_gpo;
   logic [1:0] m_oe, m_out;
   logic       m_sel;
   logic [7:0] m_ch [8];

   function automatic logic [7:0] hexc(input logic [3:0] n);
      return (n < 10) ? 8'h30 + {4'h0, n} : 8'h41 + {4'h0, n} - 8'd10;
   endfunction

   function automatic logic [63:0] m_disp();
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[8*i +: 8] = m_ch[i];
      return v;
   endfunction

   function automatic logic [31:0] m_read(input logic [19:0] o);
      case (o)
         20'h00208: return 32'h10;
         20'h00408: return {24'h0, m_led};
         20'h00508: return {24'h0, m_brk};
         20'h00A00: return {24'h0, m_gpo};
         20'h00A08: return m_sel ? {30'h0, m_out} : 32'h0;
         20'h00B00: return 32'h3;
         20'h00B08: return {30'h0, m_oe};
         20'h00B10: return {30'h0, m_out};
         20'h00B18: return {31'h0, m_sel};
         default:   return 32'h0;
      endcase
   endfunction

   function automatic void m_write(input logic [19:0] o, input logic [31:0] d);
      case (o)
         20'h00408: m_led = d[7:0];
         20'h00410: for (int i = 0; i < 8; i++) m_ch[i] = hexc(d[4*(7-i) +: 4]);
         20'h00508: m_brk = d[7:0];
         20'h00A00: m_gpo = d[7:0];
         20'h00B08: m_oe  = d[1:0];
         20'h00B10: m_out = d[1:0];
         20'h00B18: m_sel = d[0];
         default: if (o >= 20'h00418 && o <= 20'h00450 && o[2:0] == 3'b000)
                     m_ch[(o - 20'h00418) >> 3] = d[7:0];
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic outs_chk(input string req);
      chk(req, {32'h0, led, brk, gpo, 4'h0, oe, outv}, {32'h0, m_led, m_brk, m_gpo, 4'h0, m_oe, m_out});
      chk(req, disp, m_disp());
   endtask

   // write: drive after falling edge, capture on rising edge, sample 1 ns later
   task automatic bwrite(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      #1 wr = 1'b0;
      m_write(a[19:0], d);
   endtask

   task automatic bread(input logic [31:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 v = rdata;
      rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [31:0] a);
      logic [31:0] v;
      bread(a, v);
      chk(req, {32'h0, v}, {32'h0, m_read(a[19:0])});
   endtask

   // simultaneous read and write of one address
   task automatic rw_chk(input string req, input logic [31:0] a, input logic [31:0] d);
      logic [31:0] v;
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1; rd = 1'b1;
      #1 v = rdata;
      chk(req, {32'h0, v}, {32'h0, m_read(a[19:0])});
      @(posedge clk);
      #1 wr = 1'b0; rd = 1'b0;
      m_write(a[19:0], d);
      rd_chk(req, a);
   endtask

   localparam int NOFF = 24;
   localparam logic [19:0] OFFS [NOFF] = '{
      20'h00200, 20'h00208, 20'h00210, 20'h00408, 20'h00410, 20'h00418,
      20'h00420, 20'h00428, 20'h00430, 20'h00438, 20'h00440, 20'h00448,
      20'h00450, 20'h00500, 20'h00508, 20'h00A00, 20'h00A08, 20'h00B00,
      20'h00B08, 20'h00B10, 20'h00B18, 20'h00458, 20'h0041C, 20'hFFFFC
   };

   initial begin
      #800000;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      m_led = 8'h00; m_brk = 8'h0A; m_gpo = 8'h00; m_oe = 2'd0; m_out = 2'd3; m_sel = 1'b1;
      for (int i = 0; i < 8; i++) m_ch[i] = 8'h20;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10 R6 R7 reset state
      chk("R10", {56'h0, led}, 64'h0);
      chk("R10", disp, {8{8'h20}});
      chk("R6", {48'h0, brk, gpo}, {48'h0, 8'h0A, 8'h00});
      chk("R7", {60'h0, oe, outv}, {60'h0, 2'd0, 2'd3});
      rd_chk("R9", 32'h00000B18);
      rd_chk("R9", 32'h00000A08);

      // R8 constant locations, writes ignored
      bwrite(32'h00000200, 32'hFFFFFFFF);
      bwrite(32'h00000210, 32'h12345678);
      rd_chk("R8", 32'h00000200);
      rd_chk("R8", 32'h00000210);
      rd_chk("R8", 32'h00000208);
      rd_chk("R8", 32'h00000B00);

      // R1 aliasing, R2 width
      bwrite(32'hFFF00408, 32'hDEADBEA5);
      chk("R2", {56'h0, led}, 64'hA5);
      rd_chk("R1", 32'h00100408);
      rd_chk("R2", 32'h00000408);

      // R3 hex word
      bwrite(32'h00000410, 32'h0A1B2CFF);
      chk("R3", disp, {"F","F","C","2","B","1","A","0"});
      // R4 single character, last cell
      bwrite(32'h00000450, 32'h0000517A);
      chk("R4", disp, m_disp());
      chk("R4", {56'h0, disp[63:56]}, 64'h7A);
      // R11 one stride past the last cell and an odd offset change nothing
      bwrite(32'h00000458, 32'h00000041);
      bwrite(32'h0000041C, 32'h00000041);
      outs_chk("R11");
      rd_chk("R11", 32'h00000458);

      // R5 soft reset
      bwrite(32'h00000500, 32'h00000042);
      chk("R5", {63'h0, rreq}, 64'h1);
      @(posedge clk); #1;
      chk("R5", {63'h0, rreq}, 64'h0);
      bwrite(32'h00000500, 32'h00000142);
      chk("R5", {63'h0, rreq}, 64'h0);
      bwrite(32'h00300500, 32'h00000042);
      chk("R1", {63'h0, rreq}, 64'h1);

      // R9 select clear then set
      bwrite(32'h00000B10, 32'h00000002);
      bwrite(32'h00000B18, 32'hFFFFFFFE);
      rd_chk("R9", 32'h00000A08);
      rd_chk("R9", 32'h00000B18);
      bwrite(32'h00000B18, 32'h00000001);
      rd_chk("R9", 32'h00000A08);

      // R12 read and write together
      rw_chk("R12", 32'h00000408, 32'h0000003C);
      rw_chk("R12", 32'h00000A00, 32'h000000C3);
      rw_chk("R12", 32'h00000B18, 32'h00000000);

      // R6 R7 directed read-back
      bwrite(32'h00000508, 32'h1234);
      rd_chk("R6", 32'h00000508);
      bwrite(32'h00000B08, 32'hFF);
      rd_chk("R7", 32'h00000B08);

      // random phase
      for (int n = 0; n < 400; n++) begin
         logic [19:0] o;
         logic [31:0] a, d;
         o = OFFS[$urandom_range(NOFF - 1)];
         a = {12'($urandom), o};
         d = $urandom;
         if ($urandom_range(3) == 0) d = 32'h00000042;
         if ($urandom_range(1) == 0) begin
            bwrite(a, d);
            chk("R5", {63'h0, rreq}, {63'h0, (o == 20'h00500 && d == 32'h42)});
            outs_chk("R4");
         end else begin
            rd_chk("R11", a);
         end
      end

      rd = 1'b0; #1;
      chk("R11", {32'h0, rdata}, 64'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule